// File: doc/BRIEF.md
# Up-Down PWM Generator with Direction-Aware Compare Actions

This block drives a pair of complementary PWM outputs from a symmetric triangle counter. A prescaler built from two cascaded power-of-two dividers turns the system clock into count ticks. On each tick the counter steps one count toward the programmed period, turns round, and steps back down to zero. One triangle therefore lasts twice the period value in ticks.

A single compare value decides where the outputs switch. Writes go to a shadow copy. The shadow reaches the working compare only on a tick at which the counter is at zero, so a new duty cycle always starts on a clean triangle boundary. When the counter equals the working compare on a tick, each output is set or cleared according to the current count direction. Output A rises on the rising slope and falls on the falling slope. Output B does the reverse.

A one-cycle zero strobe marks each trough of the triangle for downstream logic. With the enable low, the counter, the prescalers and both outputs rest at zero.

Top module: `updown_pwm_gen`

## Requirements
- R1: A count tick occurs once every 2^(div_hi + div_lo) clocks. Each code is 0 to 7. The first tick after enable rises falls in the last clock of the first such interval.
- R2: On successive ticks the counter runs 0, 1, …, P, P-1, …, 1, 0, 1, … for a nonzero period P. The value P is reached once per triangle, so a triangle spans 2·P ticks.
- R3: On a tick where the count equals the working compare, pwm_a is set if the count is rising and cleared if it is falling. A match at P counts as rising. A match at 0 counts as falling.
- R4: On the same matches pwm_b takes the opposite action: it is cleared on a rising match and set on a falling match. pwm_a and pwm_b are never high together.
- R5: The count, pwm_a and pwm_b are registered. Each shows the effect of a tick in the clock that follows the tick.
- R6: A write (cmp_wr high) stores cmp_data in the shadow. The working compare takes the shadow value only on a tick with count 0. A write made in the very clock of such a tick takes effect at the next trough.
- R7: After reset, count, pwm_a, pwm_b and zero_evt are 0, and both the shadow and the working compare hold RST_CMP (default 3000).
- R8: zero_evt is high exactly during a clock in which enable is high, a tick occurs and the count is 0. With a nonzero period it never stays high for two clocks in a row.
- R9: While enable is low, zero_evt is 0. One clock after enable falls, count, pwm_a and pwm_b are 0 and the prescalers restart.
- R10: A working compare greater than the period never matches, so pwm_a and pwm_b keep their values.
- R11: With period 0 the counter stays at 0 and every tick raises zero_evt. That trough is treated as falling for the actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the time base; low holds everything at zero |
| period | input | CNT_W | Peak value of the triangle |
| cmp_wr | input | 1 | Write strobe for the compare shadow |
| cmp_data | input | CNT_W | Value written to the compare shadow |
| div_hi | input | CODE_W | First prescaler stage, divides by 2^code |
| div_lo | input | CODE_W | Second prescaler stage, divides by 2^code |
| pwm_a | output | 1 | Output set on rising match, cleared on falling match |
| pwm_b | output | 1 | Output cleared on rising match, set on falling match |
| zero_evt | output | 1 | One-clock strobe on a tick at count 0 |
| count | output | CNT_W | Current counter value |
| count_up | output | 1 | High while the counter is on its rising slope |

## Verification
The hardest case to reach is a shadow write that lands in the exact clock of a zero tick. That write must wait a whole triangle before it takes effect. A write of 0 adds a second hard case, because the only match is then a falling match at the trough.

The stimulus counts clocks from the rise of enable. It places the write on the tick index the triangle puts at zero, using a one-clock prescale so the tick index equals the clock index. Further runs cover these corners:
- a compare equal to zero;
- a compare above the period;
- a zero period;
- a compare left at its reset value and run with the full 6000-count period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2
    } act_e;

    localparam int N_OUT = 2;

    // output 0 rises on the rising slope, output 1 is its complement
    function automatic act_e rising_action(int idx);
        return (idx == 0) ? ACT_SET : ACT_CLR;
    endfunction

    function automatic act_e falling_action(int idx);
        return (idx == 0) ? ACT_CLR : ACT_SET;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int CODE_W = 3,
    parameter int N_STG  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_i,
    input  logic [N_STG-1:0][CODE_W-1:0] code_i,
    output logic                         tick_o
);

    localparam int STG_W = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [STG_W-1:0] cnt;
    } stg_t;

    logic [N_STG:0] en_chain;

    assign en_chain[0] = run_i;

    for (genvar g = 0; g < N_STG; g++) begin : g_stage
        stg_t             s_d, s_q;
        logic [STG_W-1:0] lim;
        logic             wrap;

        always_comb begin
            lim  = STG_W'(({{STG_W{1'b0}}, 1'b1} << code_i[g]) - 1'b1);
            wrap = en_chain[g] && (s_q.cnt == lim);
            s_d  = s_q;
            if (!run_i) begin
                s_d.cnt = '0;
            end else if (en_chain[g]) begin
                s_d.cnt = wrap ? '0 : s_q.cnt + 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign en_chain[g+1] = wrap;

        // R1
        stg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run_i && $stable(code_i[g]) && s_q.cnt <= lim) |=> (s_q.cnt <= lim));
    end

    assign tick_o = en_chain[N_STG];

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output dir_e             dir_o,
    output logic             zero_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        dir_e             dir;
    } tb_t;

    tb_t tb_d, tb_q;

    always_comb begin
        tb_d = tb_q;
        if (!run_i) begin
            tb_d = '{cnt: '0, dir: DIR_DOWN};
        end else if (tick_i) begin
            if (period_i == '0) begin
                tb_d = '{cnt: '0, dir: DIR_DOWN};
            end else if (tb_q.dir == DIR_UP) begin
                if (tb_q.cnt >= period_i) begin
                    tb_d.cnt = tb_q.cnt - 1'b1;
                    tb_d.dir = DIR_DOWN;
                end else begin
                    tb_d.cnt = tb_q.cnt + 1'b1;
                end
            end else begin
                if (tb_q.cnt == '0) begin
                    tb_d.cnt = CNT_W'(1);
                    tb_d.dir = DIR_UP;
                end else begin
                    tb_d.cnt = tb_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tb_q <= '{cnt: '0, dir: DIR_DOWN};
        else        tb_q <= tb_d;
    end

    assign cnt_o  = tb_q.cnt;
    assign dir_o  = tb_q.dir;
    assign zero_o = run_i && tick_i && (tb_q.cnt == '0);

    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && period_i != '0 && $stable(period_i))
        |=> (tb_q.cnt == $past(tb_q.cnt) + 1'b1 || tb_q.cnt == $past(tb_q.cnt) - 1'b1));

    // R2
    bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $stable(period_i) && tb_q.cnt <= period_i) |=> (tb_q.cnt <= period_i));

    // R9
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (tb_q.cnt == '0 && tb_q.dir == DIR_DOWN));

endmodule

// File: rtl/pwm_cmp_shadow.sv
module pwm_cmp_shadow #(
    parameter int CNT_W   = 16,
    parameter int RST_CMP = 3000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] data_i,
    input  logic             load_i,
    output logic [CNT_W-1:0] active_o
);

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [CNT_W-1:0] active;
    } cmp_t;

    localparam logic [CNT_W-1:0] CMP_INIT = CNT_W'(RST_CMP);

    cmp_t cmp_d, cmp_q;

    always_comb begin
        cmp_d = cmp_q;
        if (load_i) cmp_d.active = cmp_q.shadow;
        if (wr_i)   cmp_d.shadow = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmp_q <= '{shadow: CMP_INIT, active: CMP_INIT};
        else        cmp_q <= cmp_d;
    end

    assign active_o = cmp_q.active;

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  dir_e             dir_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [N_OUT-1:0] pin_o
);

    typedef struct packed {
        logic [N_OUT-1:0] pin;
    } aq_t;

    aq_t  aq_d, aq_q;
    act_e act_sel [N_OUT];
    logic match;

    for (genvar i = 0; i < N_OUT; i++) begin : g_act
        assign act_sel[i] = (dir_i == DIR_UP) ? rising_action(i) : falling_action(i);
    end

    always_comb begin
        match = tick_i && (cnt_i == cmp_i);
        aq_d  = aq_q;
        if (!run_i) begin
            aq_d.pin = '0;
        end else if (match) begin
            for (int i = 0; i < N_OUT; i++) begin
                case (act_sel[i])
                    ACT_SET: aq_d.pin[i] = 1'b1;
                    ACT_CLR: aq_d.pin[i] = 1'b0;
                    default: aq_d.pin[i] = aq_q.pin[i];
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) aq_q <= '0;
        else        aq_q <= aq_d;
    end

    assign pin_o = aq_q.pin;

    // R4
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(aq_q.pin));

    // R9
    aq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (aq_q.pin == '0));

endmodule

// File: rtl/updown_pwm_gen.sv
module updown_pwm_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int CODE_W  = 3,
    parameter int RST_CMP = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  period,
    input  logic              cmp_wr,
    input  logic [CNT_W-1:0]  cmp_data,
    input  logic [CODE_W-1:0] div_hi,
    input  logic [CODE_W-1:0] div_lo,
    output logic              pwm_a,
    output logic              pwm_b,
    output logic              zero_evt,
    output logic [CNT_W-1:0]  count,
    output logic              count_up
);

    localparam int N_STG = 2;

    logic [N_STG-1:0][CODE_W-1:0] codes;
    logic                         tick;
    logic [CNT_W-1:0]             cnt;
    dir_e                         dir;
    logic                         zero;
    logic [CNT_W-1:0]             cmp_act;
    logic [N_OUT-1:0]             pins;

    assign codes = {div_lo, div_hi};

    pwm_prescaler #(.CODE_W(CODE_W), .N_STG(N_STG)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (enable),
        .code_i (codes),
        .tick_o (tick)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (enable),
        .tick_i   (tick),
        .period_i (period),
        .cnt_o    (cnt),
        .dir_o    (dir),
        .zero_o   (zero)
    );

    pwm_cmp_shadow #(.CNT_W(CNT_W), .RST_CMP(RST_CMP)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cmp_wr),
        .data_i   (cmp_data),
        .load_i   (zero),
        .active_o (cmp_act)
    );

    pwm_action_qual #(.CNT_W(CNT_W)) u_aq (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (enable),
        .tick_i (tick),
        .cnt_i  (cnt),
        .dir_i  (dir),
        .cmp_i  (cmp_act),
        .pin_o  (pins)
    );

    assign pwm_a    = pins[0];
    assign pwm_b    = pins[1];
    assign zero_evt = zero;
    assign count    = cnt;
    assign count_up = (dir == DIR_UP);

    // R6
    active_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_evt |=> $stable(cmp_act));

    // R8
    zero_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && period != '0 && $stable(period)) |=> !zero_evt);

endmodule

// File: tb/updown_pwm_gen_tb_top.sv
module updown_pwm_gen_tb_top;

    localparam int CW = 16;
    localparam int KW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          cmp_wr = 1'b0;
    logic [CW-1:0] period = '0;
    logic [CW-1:0] cmp_data = '0;
    logic [KW-1:0] div_hi = '0;
    logic [KW-1:0] div_lo = '0;
    logic          pwm_a, pwm_b, zero_evt, count_up;
    logic [CW-1:0] count;

    updown_pwm_gen #(.CNT_W(CW), .CODE_W(KW), .RST_CMP(3000)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .period(period),
        .cmp_wr(cmp_wr), .cmp_data(cmp_data), .div_hi(div_hi), .div_lo(div_lo),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .zero_evt(zero_evt),
        .count(count), .count_up(count_up)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int            at;
        logic [CW-1:0] cnt;
        logic          a;
        logic          b;
        logic          z;
        string         tag;
    } item_t;

    item_t         exp_q[$];
    int            n_chk = 0;
    int            n_err = 0;
    bit            mon_on = 1'b0;
    logic [CW+2:0] seen;
    logic [CW+2:0] m_last = '0;
    string         last_tag = "R9";
    int            m_act = 3000;
    int            m_sh  = 3000;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: %s actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // monitor: every change of the observed tuple must match the next queued item
    always @(negedge clk) begin
        if (mon_on) begin
            logic [CW+2:0] cur;
            cur = {count, pwm_a, pwm_b, zero_evt};
            if (cur !== seen) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_err++;
                    $display("FAIL %s: unexpected change at cycle %0d actual %h expected %h",
                             last_tag, cyc, cur, seen);
                end else begin
                    item_t it;
                    it = exp_q.pop_front();
                    last_tag = it.tag;
                    n_chk++;
                    if (it.at != cyc || cur !== {it.cnt, it.a, it.b, it.z}) begin
                        n_err++;
                        $display("FAIL %s: cycle %0d tuple %h expected cycle %0d tuple %h",
                                 it.tag, cyc, cur, it.at, {it.cnt, it.a, it.b, it.z});
                    end
                end
                seen = cur;
            end
        end
    end

    task automatic push_if(int at, int c, bit a, bit b, bit z, string tag);
        logic [CW+2:0] v;
        v = {CW'(c), a, b, z};
        if (v !== m_last) begin
            item_t it;
            it.at = at; it.cnt = CW'(c); it.a = a; it.b = b; it.z = z; it.tag = tag;
            exp_q.push_back(it);
        end
        m_last = v;
    endtask

    task automatic write_cmp(int v);
        @(posedge clk); #1;
        cmp_wr = 1'b1; cmp_data = CW'(v);
        @(posedge clk); #1;
        cmp_wr = 1'b0;
        m_sh = v;
    endtask

    task automatic run_case(string tag, int p, int hi, int lo, int n, int wr_j, int wr_v);
        int d, mc, g;
        bit up, a, b, tick;
        @(posedge clk); #1;
        period = CW'(p); div_hi = KW'(hi); div_lo = KW'(lo);
        @(posedge clk); #1;
        g = cyc;
        d = 1 << (hi + lo);
        mc = 0; up = 1'b0; a = 1'b0; b = 1'b0;
        for (int j = 0; j < n; j++) begin
            tick = ((j + 1) % d) == 0;
            push_if(g + j, mc, a, b, tick && mc == 0, tag);
            if (tick) begin
                if (mc == m_act) begin
                    a = up;
                    b = !up;
                end
                if (mc == 0) m_act = m_sh;
                if (p == 0) begin
                    mc = 0; up = 1'b0;
                end else if (up) begin
                    if (mc >= p) begin mc--; up = 1'b0; end
                    else mc++;
                end else begin
                    if (mc == 0) begin mc = 1; up = 1'b1; end
                    else mc--;
                end
            end
            if (j == wr_j) m_sh = wr_v;
        end
        push_if(g + n, mc, a, b, 1'b0, tag);
        push_if(g + n + 1, 0, 1'b0, 1'b0, 1'b0, tag);
        enable = 1'b1;
        cmp_wr = (wr_j == 0);
        cmp_data = CW'(wr_v);
        for (int j = 1; j < n; j++) begin
            @(posedge clk); #1;
            cmp_wr = (j == wr_j);
        end
        @(posedge clk); #1;
        enable = 1'b0;
        cmp_wr = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        // R9: everything back at rest after disable
        chk(count == '0 && !pwm_a && !pwm_b && !zero_evt, "R9", "rest state after disable",
            int'({count, pwm_a, pwm_b, zero_evt}), 0);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        // R7: reset state at the ports
        chk(count == '0, "R7", "count after reset", int'(count), 0);
        chk(!pwm_a && !pwm_b, "R7", "outputs after reset", int'({pwm_a, pwm_b}), 0);
        chk(!zero_evt, "R7", "zero_evt after reset", int'(zero_evt), 0);
        seen = {count, pwm_a, pwm_b, zero_evt};
        mon_on = 1'b1;

        // R9: disabled, nothing moves
        period = CW'(10);
        repeat (20) @(posedge clk);
        #1;
        chk(count == '0 && !zero_evt, "R9", "held while disabled", int'(count), 0);

        // R7: reset compare 3000 with period 6000 gives half duty
        run_case("R7", 6000, 0, 0, 12010, -1, 0);
        // R3: rising set, falling clear on output A
        write_cmp(3);
        run_case("R3", 8, 0, 0, 40, -1, 0);
        // R4: complementary output with a divide by 2
        write_cmp(2);
        run_case("R4", 5, 1, 0, 50, -1, 0);
        // R1: cascaded prescale 4 * 2
        write_cmp(1);
        run_case("R1", 4, 2, 1, 100, -1, 0);
        // R5: one-clock latency at full rate
        run_case("R5", 3, 0, 0, 20, -1, 0);
        // R6: write of 0 in the zero-tick clock j=12 waits until j=24
        write_cmp(2);
        run_case("R6", 6, 0, 0, 60, 12, 0);
        // R2: triangle stopped mid-slope
        write_cmp(3);
        run_case("R2", 7, 1, 0, 35, -1, 0);
        // R8: zero strobe spacing with divide by 4
        run_case("R8", 3, 1, 1, 60, -1, 0);
        // R10: compare above period never matches
        write_cmp(9);
        run_case("R10", 5, 0, 0, 30, -1, 0);
        // R11: zero period, compare 0 matches as falling
        write_cmp(0);
        run_case("R11", 0, 0, 0, 6, -1, 0);

        repeat (4) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R2", "expected changes never seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(8 * 160000);
        n_chk++;
        n_err++;
        $display("FAIL R2: watchdog expired at cycle %0d expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule